// File: doc/BRIEF.md
# Protection Fault Indicator Pin Controller

This block drives two multifunction pins of a battery protection device. Pin 0 is the discharge-side pin and pin 1 is the charge-side pin. Each pin can be set to one of four roles. It can report protection faults, it can be handed to an analog front end for a thermistor or a general ADC reading, or it can act as a plain digital output. In fault-indicator mode a pin collects the fault flags that would block its side's FET driver, after each flag is qualified by its protection-enable bit. A per-pin polarity bit sets the level that the pin drives while a fault is present.

For each pin the block produces a data bit, an output enable that controls the tri-state pad, a drive-rail select, and a flag that passes the pad to the analog path. Every output is registered. When the device is in its shutdown power state, both pads are released to high impedance, whatever role they have been given. Fault reporting keeps working in the normal, sleep and deep-sleep power states.

Top module: `fipc_top`

## Requirements
- R1: While reset is active, and after it, until the first clock edge that captures new inputs, every bit of pin_data, pin_oe, pin_rail and pin_analog is 0, so both pads are high impedance.
- R2: When dsg_mode is 0 (fault indicator), pin 0 (bit 0 of each output vector) is asserted whenever some bit of fault_flags & prot_en & DSG_MASK is set. The default DSG_MASK is 8'h0F, and fault bit 0 (cell overvoltage) is part of it.
- R3: When chg_mode is 0 (fault indicator), pin 1 (bit 1 of each output vector) is asserted whenever some bit of fault_flags & prot_en & CHG_MASK is set. The default CHG_MASK is 8'hF2.
- R4: A fault flag whose prot_en bit is 0 has no effect on either pin. With no qualified fault, a fault-indicator pin stays deasserted.
- R5: In fault-indicator mode pin_oe is 1. pin_data equals pin_pol[i] while the pin is asserted and equals the inverse of pin_pol[i] while it is deasserted.
- R6: Fault indication works in power modes 0 (normal), 1 (sleep) and 2 (deep sleep).
- R7: In power mode 3 (shutdown), pin_data, pin_oe, pin_rail and pin_analog are all 0 for both pins, in every pin mode.
- R8: Mode 1 (thermistor) and mode 2 (ADC) give pin_oe = 0, pin_data = 0, pin_rail = 0 and pin_analog = 1.
- R9: Mode 3 (digital output) gives pin_oe = 1 and pin_data = gpo_val[i].
- R10: When a pin drives (pin_oe = 1), pin_rail equals rail_sel[i], where 0 selects the fixed 1.8 V rail and 1 selects the programmable rail. Otherwise pin_rail is 0.
- R11: A change on any input reaches the outputs at exactly the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 2 | Power state: 0 normal, 1 sleep, 2 deep sleep, 3 shutdown |
| fault_flags | input | N_PROT | Live protection fault flags |
| prot_en | input | N_PROT | Per-protection enable bits |
| dsg_mode | input | 2 | Role of the discharge-side pin |
| chg_mode | input | 2 | Role of the charge-side pin |
| pin_pol | input | 2 | Asserted level per pin in fault mode |
| rail_sel | input | 2 | Drive rail per pin: 0 fixed 1.8 V, 1 programmable |
| gpo_val | input | 2 | Data per pin in digital-output mode |
| pin_data | output | 2 | Registered pad data |
| pin_oe | output | 2 | Registered pad output enable |
| pin_rail | output | 2 | Registered drive-rail select |
| pin_analog | output | 2 | Registered hand-over to the analog path |

## Verification
The assertions check several rules on every cycle, each one clock after its inputs: shutdown releases both pads, analog roles never drive, the fault level follows the polarity bit when a qualified fault is present or absent, and the rail follows its select bit while a pad drives. Some behaviours only the bench's scenarios can show. These include the exact mask membership of particular fault bits (cell overvoltage reaching only the discharge pin), the fact that a change has no effect before the next edge, and the all-zero state during reset and right after it.

// File: rtl/fipc_pkg.sv
package fipc_pkg;

    localparam int NUM_PINS = 2;

    typedef enum logic [1:0] {
        ROLE_FAULT = 2'd0,
        ROLE_THERM = 2'd1,
        ROLE_ADC   = 2'd2,
        ROLE_GPO   = 2'd3
    } pin_role_e;

    typedef enum logic [1:0] {
        PWR_NORMAL = 2'd0,
        PWR_SLEEP  = 2'd1,
        PWR_DEEP   = 2'd2,
        PWR_SHUT   = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic data;
        logic oe;
        logic rail;
        logic analog;
    } pad_ctl_t;

    localparam pad_ctl_t PAD_RELEASED = '{data: 1'b0, oe: 1'b0, rail: 1'b0, analog: 1'b0};

endpackage

// File: rtl/fipc_fault_agg.sv
module fipc_fault_agg #(
    parameter int                N_PROT = 8,
    parameter logic [N_PROT-1:0] MASK   = '0
) (
    input  logic [N_PROT-1:0] flags,
    input  logic [N_PROT-1:0] enables,
    output logic              active
);
    logic [N_PROT-1:0] qualified;

    for (genvar b = 0; b < N_PROT; b++) begin : g_bit
        if (MASK[b]) begin : g_used
            assign qualified[b] = flags[b] & enables[b];
        end else begin : g_unused
            assign qualified[b] = 1'b0;
        end
    end

    assign active = |qualified;
endmodule

// File: rtl/fipc_pin_mux.sv
module fipc_pin_mux
    import fipc_pkg::*;
(
    input  logic [1:0] pwr,
    input  logic [1:0] role,
    input  logic       pol,
    input  logic       rail,
    input  logic       gpo,
    input  logic       fault_active,
    output pad_ctl_t   nxt
);
    always_comb begin
        nxt = PAD_RELEASED;
        if (pwr_state_e'(pwr) != PWR_SHUT) begin
            unique case (pin_role_e'(role))
                ROLE_FAULT: begin
                    nxt.oe   = 1'b1;
                    nxt.rail = rail;
                    nxt.data = fault_active ? pol : ~pol;
                end
                ROLE_THERM, ROLE_ADC: begin
                    nxt.analog = 1'b1;
                end
                ROLE_GPO: begin
                    nxt.oe   = 1'b1;
                    nxt.rail = rail;
                    nxt.data = gpo;
                end
                default: nxt = PAD_RELEASED;
            endcase
        end
    end
endmodule

// File: rtl/fipc_top.sv
module fipc_top
    import fipc_pkg::*;
#(
    parameter int                N_PROT   = 8,
    parameter logic [N_PROT-1:0] DSG_MASK = 'h0F,
    parameter logic [N_PROT-1:0] CHG_MASK = 'hF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pwr_mode,
    input  logic [N_PROT-1:0] fault_flags,
    input  logic [N_PROT-1:0] prot_en,
    input  logic [1:0]        dsg_mode,
    input  logic [1:0]        chg_mode,
    input  logic [1:0]        pin_pol,
    input  logic [1:0]        rail_sel,
    input  logic [1:0]        gpo_val,
    output logic [1:0]        pin_data,
    output logic [1:0]        pin_oe,
    output logic [1:0]        pin_rail,
    output logic [1:0]        pin_analog
);
    localparam int NP = NUM_PINS;

    typedef struct packed {
        pad_ctl_t [NP-1:0] pad;
    } state_t;

    state_t state_d, state_q;

    logic [NP-1:0][1:0] role_arr;
    logic [NP-1:0]      active;
    pad_ctl_t [NP-1:0]  pad_nxt;

    assign role_arr[0] = dsg_mode;
    assign role_arr[1] = chg_mode;

    for (genvar p = 0; p < NP; p++) begin : g_pin
        localparam logic [N_PROT-1:0] PMASK = (p == 0) ? DSG_MASK : CHG_MASK;

        fipc_fault_agg #(
            .N_PROT (N_PROT),
            .MASK   (PMASK)
        ) u_agg (
            .flags   (fault_flags),
            .enables (prot_en),
            .active  (active[p])
        );

        fipc_pin_mux u_mux (
            .pwr          (pwr_mode),
            .role         (role_arr[p]),
            .pol          (pin_pol[p]),
            .rail         (rail_sel[p]),
            .gpo          (gpo_val[p]),
            .fault_active (active[p]),
            .nxt          (pad_nxt[p])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int p = 0; p < NP; p++) begin
            state_d.pad[p] = pad_nxt[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{pad: {NP{PAD_RELEASED}}};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            pin_data[p]   = state_q.pad[p].data;
            pin_oe[p]     = state_q.pad[p].oe;
            pin_rail[p]   = state_q.pad[p].rail;
            pin_analog[p] = state_q.pad[p].analog;
        end
    end
endmodule

// File: rtl/fipc_chk.sv
module fipc_chk #(
    parameter int                N_PROT   = 8,
    parameter logic [N_PROT-1:0] DSG_MASK = 'h0F,
    parameter logic [N_PROT-1:0] CHG_MASK = 'hF2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pwr_mode,
    input logic [N_PROT-1:0] fault_flags,
    input logic [N_PROT-1:0] prot_en,
    input logic [1:0]        dsg_mode,
    input logic [1:0]        chg_mode,
    input logic [1:0]        pin_pol,
    input logic [1:0]        rail_sel,
    input logic [1:0]        gpo_val,
    input logic [1:0]        pin_data,
    input logic [1:0]        pin_oe,
    input logic [1:0]        pin_rail,
    input logic [1:0]        pin_analog
);
    logic [1:0][1:0] role;
    logic [1:0]      qual;
    assign role[0] = dsg_mode;
    assign role[1] = chg_mode;
    assign qual[0] = |(fault_flags & prot_en & DSG_MASK);
    assign qual[1] = |(fault_flags & prot_en & CHG_MASK);

    for (genvar i = 0; i < 2; i++) begin : g_pin
        // R7
        shut_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_mode == 2'd3) |=> (!pin_oe[i] && !pin_analog[i] && !pin_data[i] && !pin_rail[i]));

        // R8
        analog_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_mode != 2'd3 && (role[i] == 2'd1 || role[i] == 2'd2))
            |=> (pin_analog[i] && !pin_oe[i] && !pin_data[i]));

        // R2 R3 R5 R6
        fault_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_mode != 2'd3 && role[i] == 2'd0 && qual[i])
            |=> (pin_oe[i] && pin_data[i] == $past(pin_pol[i])));

        // R4
        fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_mode != 2'd3 && role[i] == 2'd0 && !qual[i])
            |=> (pin_oe[i] && pin_data[i] != $past(pin_pol[i])));

        // R9
        gpo_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_mode != 2'd3 && role[i] == 2'd3)
            |=> (pin_oe[i] && pin_data[i] == $past(gpo_val[i])));

        // R10
        rail_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_mode != 2'd3 && (role[i] == 2'd0 || role[i] == 2'd3))
            |=> (pin_rail[i] == $past(rail_sel[i])));

        // R8 R10
        pad_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pin_oe[i] && pin_analog[i]) && (pin_oe[i] || !pin_rail[i]));
    end
endmodule

bind fipc_top fipc_chk #(
    .N_PROT   (N_PROT),
    .DSG_MASK (DSG_MASK),
    .CHG_MASK (CHG_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_mode    (pwr_mode),
    .fault_flags (fault_flags),
    .prot_en     (prot_en),
    .dsg_mode    (dsg_mode),
    .chg_mode    (chg_mode),
    .pin_pol     (pin_pol),
    .rail_sel    (rail_sel),
    .gpo_val     (gpo_val),
    .pin_data    (pin_data),
    .pin_oe      (pin_oe),
    .pin_rail    (pin_rail),
    .pin_analog  (pin_analog)
);

// File: tb/fipc_top_tb.sv
`timescale 1ns/1ps
module fipc_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_mode = '0;
    logic [7:0] fault_flags = '0;
    logic [7:0] prot_en = '0;
    logic [1:0] dsg_mode = '0;
    logic [1:0] chg_mode = '0;
    logic [1:0] pin_pol = '0;
    logic [1:0] rail_sel = '0;
    logic [1:0] gpo_val = '0;
    logic [1:0] pin_data, pin_oe, pin_rail, pin_analog;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    fipc_top u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .fault_flags(fault_flags),
        .prot_en(prot_en), .dsg_mode(dsg_mode), .chg_mode(chg_mode), .pin_pol(pin_pol),
        .rail_sel(rail_sel), .gpo_val(gpo_val), .pin_data(pin_data), .pin_oe(pin_oe),
        .pin_rail(pin_rail), .pin_analog(pin_analog)
    );

    // {pwr, dmode, cmode, pol, rail, gpo, flags, en, e_data, e_oe, e_rail, e_analog}
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        {2'd0, 2'd0, 2'd0, 2'b11, 2'b00, 2'b00, 8'h00, 8'hFF, 2'b00, 2'b11, 2'b00, 2'b00},
        {2'd0, 2'd0, 2'd0, 2'b11, 2'b01, 2'b00, 8'h01, 8'hFF, 2'b01, 2'b11, 2'b01, 2'b00},
        {2'd0, 2'd0, 2'd0, 2'b11, 2'b01, 2'b00, 8'h01, 8'hFE, 2'b00, 2'b11, 2'b01, 2'b00},
        {2'd1, 2'd0, 2'd0, 2'b00, 2'b10, 2'b00, 8'h10, 8'hFF, 2'b01, 2'b11, 2'b10, 2'b00},
        {2'd2, 2'd0, 2'd0, 2'b10, 2'b00, 2'b00, 8'h02, 8'hFF, 2'b10, 2'b11, 2'b00, 2'b00},
        {2'd0, 2'd1, 2'd2, 2'b11, 2'b11, 2'b11, 8'hFF, 8'hFF, 2'b00, 2'b00, 2'b00, 2'b11},
        {2'd0, 2'd3, 2'd3, 2'b00, 2'b01, 2'b10, 8'h00, 8'h00, 2'b10, 2'b11, 2'b01, 2'b00},
        {2'd3, 2'd3, 2'd0, 2'b11, 2'b11, 2'b11, 8'hFF, 8'hFF, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd3, 2'd1, 2'd2, 2'b00, 2'b11, 2'b00, 8'h00, 8'h00, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd0, 2'd0, 2'd3, 2'b01, 2'b10, 2'b10, 8'h08, 8'h08, 2'b11, 2'b11, 2'b10, 2'b00},
        {2'd2, 2'd3, 2'd1, 2'b00, 2'b11, 2'b01, 8'h00, 8'h00, 2'b01, 2'b01, 2'b01, 2'b10},
        {2'd1, 2'd0, 2'd0, 2'b11, 2'b00, 2'b00, 8'hF0, 8'h0F, 2'b00, 2'b11, 2'b00, 2'b00}
    };

    string vtag [NV] = '{
        "R4 R5 no fault", "R2 R10 cell overvoltage", "R4 disabled overvoltage",
        "R3 R6 sleep active-low", "R2 R3 R6 deep-sleep shared fault", "R8 analog roles",
        "R9 R10 digital out", "R7 shutdown", "R7 shutdown analog roles",
        "R2 R9 mixed roles", "R8 R9 R6 mixed deep-sleep", "R4 enables mask flags"
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got {data,oe,rail,an}=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {pin_data, pin_oe, pin_rail, pin_analog};
    endfunction

    task automatic apply(input logic [35:0] v);
        pwr_mode    = v[35:34];
        dsg_mode    = v[33:32];
        chg_mode    = v[31:30];
        pin_pol     = v[29:28];
        rail_sel    = v[27:26];
        gpo_val     = v[25:24];
        fault_flags = v[23:16];
        prot_en     = v[15:8];
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state, with inputs that would otherwise drive
        apply(VEC[1]);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 during reset", outs(), 8'h00);
        rst_n = 1'b1;
        check("R1 after release before edge", outs(), 8'h00);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            apply(VEC[k]);
            @(negedge clk);
            check(vtag[k], outs(), VEC[k][7:0]);
        end

        // R11: polarity change does not show before the next edge
        @(negedge clk);
        apply({2'd0, 2'd0, 2'd0, 2'b11, 2'b00, 2'b00, 8'h01, 8'hFF, 8'h0});
        @(negedge clk);
        check("R11 R5 settled", outs(), 8'b01_11_00_00);
        pin_pol = 2'b00;
        #1;
        check("R11 before edge", outs(), 8'b01_11_00_00);
        @(negedge clk);
        check("R11 R5 after edge", outs(), 8'b10_11_00_00);

        // R7: entering shutdown while a fault is present
        pwr_mode = 2'd3;
        @(negedge clk);
        check("R7 shutdown with fault", outs(), 8'h00);

        // R6: returning to normal resumes the indication
        pwr_mode = 2'd0;
        @(negedge clk);
        check("R6 resume after shutdown", outs(), 8'b10_11_00_00);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        #1;
        check("R1 asynchronous reset", outs(), 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R5 first edge after reset", outs(), 8'b10_11_00_00);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule